// File: doc/BRIEF.md
# Same-Page Lookup Merger for a Multi-Ported Data TLB

This block sits in front of a multi-ported data TLB. In each cycle up to four memory references arrive, each with a 32-bit virtual address and a valid bit. The block compares the virtual page numbers of every pair of ports. References that fall in the same page form a group, and the group sends a single translation request. The lowest-numbered valid port of each group owns the lookup. Every other member records which lane it depends on.

The lookup lanes are registered one cycle after the addresses are sampled. The TLB array outside the block returns one physical page number per lane in that same cycle. One cycle later the block hands each reference its full physical address. That address is the page number from its group's owning lane joined with the reference's own untouched 12-bit page offset. Lookups, page walks and memory ordering are handled elsewhere.

Top module: `vpn_compactor`

## Requirements
- R1: While reset is asserted and after it is released with no input, no lookup lane and no physical-address valid bit is set.
- R2: One cycle after sampling, lookup lane p is requested exactly when port p is valid and no lower-numbered valid port has the same virtual page number (bits 31:12).
- R3: An invalid port never requests a lookup and never suppresses a higher port, even if its address has the same page as that port.
- R4: The number of requested lanes equals the number of distinct page numbers among the valid ports, and no two requested lanes carry the same page number.
- R5: A requested lane carries the page number of its own port on `lk_vpn` (lane p at bits p*20 +: 20).
- R6: Two cycles after sampling, each valid port's physical address has, in its upper 20 bits, the `lk_ppn` value returned on the lane of the lowest valid port sharing its page.
- R7: `pa_valid` repeats the input valid vector two cycles later, and the low 12 bits of each valid port's physical address equal that port's input page offset.
- R8: Three valid references at 0xdeadbeee, 0xdeadbeef and 0xdeadbef0 produce exactly one lookup, on lane 0, for page 0xdeadb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Per-port reference valid |
| in_va | input | 128 | Per-port virtual address, port p at bits p*32 +: 32 |
| lk_req | output | 4 | Per-lane TLB lookup request |
| lk_vpn | output | 80 | Per-lane page number to translate |
| lk_ppn | input | 80 | Per-lane translated page number, returned in the same cycle as the request |
| pa_valid | output | 4 | Per-port physical address valid |
| pa | output | 128 | Per-port physical address, port p at bits p*32 +: 32 |

## Verification
The bench uses the default four ports with 20-bit page numbers. It draws each port's page from a pool of four values: a base page, one that differs only in bit 0, one that differs only in the top bit, and one unrelated page. Every valid mask is combined with every page assignment, 4096 vectors in all. This covers every pair, triple and full-group pattern, every placement of invalid synonyms, and single-bit near-misses at both ends of the comparator. The TLB is modelled as an arithmetic function of the requested page. A wrong source lane therefore shows up as a wrong physical address.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  // flat index of unordered pair (i,j), i<j, among n ports
  function automatic int pair_index(input int i, input int j, input int n);
    return i * n - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction
endpackage

// File: rtl/vpc_match_net.sv
module vpc_match_net #(
  parameter int N     = 4,
  parameter int VPN_W = 20,
  parameter int SRC_W = 2
) (
  input  logic [N-1:0]       valid,
  input  logic [N*VPN_W-1:0] vpn_flat,
  output logic [N-1:0]       issue,
  output logic [N*SRC_W-1:0] src_flat
);
  localparam int NPAIR = N * (N - 1) / 2;

  logic [NPAIR-1:0] pair_eq;

  // one equality comparator per unordered port pair
  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
      assign pair_eq[vpc_pkg::pair_index(gi, gj, N)] =
        valid[gi] & valid[gj] &
        (vpn_flat[gi*VPN_W +: VPN_W] == vpn_flat[gj*VPN_W +: VPN_W]);
    end
  end

  // lowest matching lower port becomes the source; otherwise self
  always_comb begin
    issue    = '0;
    src_flat = '0;
    for (int j = 0; j < N; j++) begin
      logic [SRC_W-1:0] src;
      logic             dup;
      src = SRC_W'(j);
      dup = 1'b0;
      for (int i = j - 1; i >= 0; i--) begin
        if (pair_eq[vpc_pkg::pair_index(i, j, N)]) begin
          src = SRC_W'(i);
          dup = 1'b1;
        end
      end
      issue[j]                    = valid[j] & ~dup;
      src_flat[j*SRC_W +: SRC_W] = src;
    end
  end
endmodule

// File: rtl/vpc_lookup_stage.sv
module vpc_lookup_stage #(
  parameter int N     = 4,
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int SRC_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       valid_in,
  input  logic [N-1:0]       issue_in,
  input  logic [N*VPN_W-1:0] vpn_in,
  input  logic [N*OFF_W-1:0] off_in,
  input  logic [N*SRC_W-1:0] src_in,
  output logic [N-1:0]       valid_q,
  output logic [N-1:0]       req_q,
  output logic [N*VPN_W-1:0] vpn_q,
  output logic [N*OFF_W-1:0] off_q,
  output logic [N*SRC_W-1:0] src_q
);
  logic [N-1:0] valid_d, req_d;

  always_comb begin
    valid_d = valid_in;
    req_d   = issue_in & valid_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      req_q   <= '0;
    end else begin
      valid_q <= valid_d;
      req_q   <= req_d;
    end
  end

  // data lanes load only when they carry something
  for (genvar gp = 0; gp < N; gp++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_q[gp*VPN_W +: VPN_W] <= '0;
        off_q[gp*OFF_W +: OFF_W] <= '0;
        src_q[gp*SRC_W +: SRC_W] <= '0;
      end else begin
        if (req_d[gp]) vpn_q[gp*VPN_W +: VPN_W] <= vpn_in[gp*VPN_W +: VPN_W];
        if (valid_d[gp]) begin
          off_q[gp*OFF_W +: OFF_W] <= off_in[gp*OFF_W +: OFF_W];
          src_q[gp*SRC_W +: SRC_W] <= src_in[gp*SRC_W +: SRC_W];
        end
      end
    end
  end
endmodule

// File: rtl/vpc_fanout_stage.sv
module vpc_fanout_stage #(
  parameter int N     = 4,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12,
  parameter int SRC_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               valid_in,
  input  logic [N*SRC_W-1:0]         src_in,
  input  logic [N*OFF_W-1:0]         off_in,
  input  logic [N*PPN_W-1:0]         ppn_in,
  output logic [N-1:0]               valid_q,
  output logic [N*(PPN_W+OFF_W)-1:0] pa_q
);
  localparam int PA_W = PPN_W + OFF_W;

  logic [N*PA_W-1:0] pa_d;

  always_comb begin
    pa_d = '0;
    for (int p = 0; p < N; p++) begin
      logic [SRC_W-1:0] s;
      s = src_in[p*SRC_W +: SRC_W];
      pa_d[p*PA_W +: PA_W] = {ppn_in[int'(s)*PPN_W +: PPN_W], off_in[p*OFF_W +: OFF_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_in;
  end

  for (genvar gp = 0; gp < N; gp++) begin : g_pa
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pa_q[gp*PA_W +: PA_W] <= '0;
      else if (valid_in[gp]) pa_q[gp*PA_W +: PA_W] <= pa_d[gp*PA_W +: PA_W];
    end
  end
endmodule

// File: rtl/vpn_compactor.sv
module vpn_compactor #(
  parameter int N     = 4,
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               in_valid,
  input  logic [N*VA_W-1:0]          in_va,
  output logic [N-1:0]               lk_req,
  output logic [N*(VA_W-OFF_W)-1:0]  lk_vpn,
  input  logic [N*PPN_W-1:0]         lk_ppn,
  output logic [N-1:0]               pa_valid,
  output logic [N*(PPN_W+OFF_W)-1:0] pa
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int SRC_W = (N > 1) ? $clog2(N) : 1;

  logic [N*VPN_W-1:0] vpn_split;
  logic [N*OFF_W-1:0] off_split;
  logic [N-1:0]       issue;
  logic [N*SRC_W-1:0] src;
  logic [N-1:0]       s1_valid;
  logic [N*OFF_W-1:0] s1_off;
  logic [N*SRC_W-1:0] s1_src;

  for (genvar gp = 0; gp < N; gp++) begin : g_split
    assign vpn_split[gp*VPN_W +: VPN_W] = in_va[gp*VA_W + OFF_W +: VPN_W];
    assign off_split[gp*OFF_W +: OFF_W] = in_va[gp*VA_W +: OFF_W];
  end

  vpc_match_net #(.N(N), .VPN_W(VPN_W), .SRC_W(SRC_W)) u_match (
    .valid(in_valid), .vpn_flat(vpn_split), .issue(issue), .src_flat(src)
  );

  vpc_lookup_stage #(.N(N), .VPN_W(VPN_W), .OFF_W(OFF_W), .SRC_W(SRC_W)) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .valid_in(in_valid), .issue_in(issue), .vpn_in(vpn_split),
    .off_in(off_split), .src_in(src),
    .valid_q(s1_valid), .req_q(lk_req), .vpn_q(lk_vpn),
    .off_q(s1_off), .src_q(s1_src)
  );

  vpc_fanout_stage #(.N(N), .PPN_W(PPN_W), .OFF_W(OFF_W), .SRC_W(SRC_W)) u_fanout (
    .clk(clk), .rst_n(rst_n),
    .valid_in(s1_valid), .src_in(s1_src), .off_in(s1_off), .ppn_in(lk_ppn),
    .valid_q(pa_valid), .pa_q(pa)
  );
endmodule

// File: rtl/vpn_compactor_chk.sv
module vpn_compactor_chk #(
  parameter int N     = 4,
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N-1:0]               in_valid,
  input logic [N*VA_W-1:0]          in_va,
  input logic [N-1:0]               lk_req,
  input logic [N*(VA_W-OFF_W)-1:0]  lk_vpn,
  input logic [N-1:0]               pa_valid,
  input logic [N*(PPN_W+OFF_W)-1:0] pa
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_IDLE_IN_RESET: assert property (@(posedge clk) !rst_n |-> (lk_req == '0 && pa_valid == '0)); // R1

  AST_PORT0_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[0] |=> lk_req[0]); // R2

  AST_REQ_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0) |-> ((lk_req & ~$past(in_valid)) == '0)); // R3

  AST_SOME_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid != '0) |=> (lk_req != '0)); // R4

  AST_PA_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (pa_valid == $past(in_valid, 2))); // R7

  for (genvar gi = 0; gi < N; gi++) begin : g_i
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && pa_valid[gi]) |->
      (pa[gi*PA_W +: OFF_W] == $past(in_va[gi*VA_W +: OFF_W], 2))); // R7
    for (genvar gj = gi + 1; gj < N; gj++) begin : g_j
      AST_DISTINCT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req[gi] && lk_req[gj]) |->
        (lk_vpn[gi*VPN_W +: VPN_W] != lk_vpn[gj*VPN_W +: VPN_W])); // R4
    end
  end
endmodule

bind vpn_compactor vpn_compactor_chk #(.N(N), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_va(in_va),
  .lk_req(lk_req), .lk_vpn(lk_vpn), .pa_valid(pa_valid), .pa(pa)
);

// File: tb/vpn_compactor_bench.sv
`timescale 1ns/100ps
module vpn_compactor_bench;
  localparam int N = 4;
  localparam int VA_W = 32;
  localparam int OFF_W = 12;
  localparam int PPN_W = 20;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [N-1:0]       in_valid;
  logic [N*VA_W-1:0]  in_va;
  logic [N-1:0]       lk_req;
  logic [N*VPN_W-1:0] lk_vpn;
  logic [N*PPN_W-1:0] lk_ppn;
  logic [N-1:0]       pa_valid;
  logic [N*PA_W-1:0]  pa;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vpn_compactor u_vpn_compactor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_va(in_va),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_ppn(lk_ppn),
    .pa_valid(pa_valid), .pa(pa)
  );

  function automatic logic [PPN_W-1:0] xlate(input logic [VPN_W-1:0] v);
    return PPN_W'((v * 3) + 20'h1357);
  endfunction

  for (genvar gl = 0; gl < N; gl++) begin : g_tlb
    assign lk_ppn[gl*PPN_W +: PPN_W] = xlate(lk_vpn[gl*VPN_W +: VPN_W]);
  end

  function automatic logic [VPN_W-1:0] pool(input int c);
    case (c)
      0: return 20'hdeadb;
      1: return 20'hdeada;
      2: return 20'h5eadb;
      default: return 20'h12345;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0;
    in_va = '0;
    repeat (3) @(negedge clk);
    check(lk_req == '0 && pa_valid == '0, "R1 in reset", {lk_req, pa_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(lk_req == '0 && pa_valid == '0, "R1 after release", {lk_req, pa_valid}, 0);

    // R8 directed example
    in_valid = 4'b0111;
    in_va = {32'h0, 32'hdeadbef0, 32'hdeadbeef, 32'hdeadbeee};
    @(negedge clk);
    check(lk_req == 4'b0001, "R8 lanes", lk_req, 4'b0001);
    check(lk_vpn[0 +: VPN_W] == 20'hdeadb, "R8 page", lk_vpn[0 +: VPN_W], 20'hdeadb);
    @(negedge clk);
    check(pa[2*PA_W +: PA_W] == {xlate(20'hdeadb), 12'hef0}, "R8 R6 address",
          pa[2*PA_W +: PA_W], {xlate(20'hdeadb), 12'hef0});

    // exhaustive sweep: valid mask x page code per port
    for (int v = 0; v < 16; v++) begin
      for (int cs = 0; cs < 256; cs++) begin
        int code [N];
        logic [N-1:0] exp_req;
        int exp_src [N];
        int distinct;
        logic [11:0] off [N];
        for (int p = 0; p < N; p++) begin
          code[p] = (cs >> (2 * p)) & 3;
          off[p] = 12'((v * 256 + cs) * 7 + p * 12'h3a1);
          in_va[p*VA_W +: VA_W] = {pool(code[p]), off[p]};
        end
        in_valid = 4'(v);
        distinct = 0;
        for (int p = 0; p < N; p++) begin
          exp_src[p] = p;
          for (int q = p - 1; q >= 0; q--)
            if (v[q] && code[q] == code[p]) exp_src[p] = q;
          exp_req[p] = v[p] && exp_src[p] == p;
          if (exp_req[p]) distinct++;
        end
        @(negedge clk);
        check(lk_req == exp_req, "R2 R3 lane set", lk_req, exp_req);
        check($countones(lk_req) == distinct, "R4 lookup count", $countones(lk_req), distinct);
        for (int p = 0; p < N; p++)
          if (exp_req[p])
            check(lk_vpn[p*VPN_W +: VPN_W] == pool(code[p]), "R5 lane page",
                  lk_vpn[p*VPN_W +: VPN_W], pool(code[p]));
        @(negedge clk);
        check(pa_valid == 4'(v), "R7 valid delay", pa_valid, 4'(v));
        for (int p = 0; p < N; p++)
          if (v[p])
            check(pa[p*PA_W +: PA_W] == {xlate(pool(code[exp_src[p]])), off[p]},
                  "R6 R7 physical address", pa[p*PA_W +: PA_W],
                  {xlate(pool(code[exp_src[p]])), off[p]});
      end
    end
    in_valid = '0;
    repeat (2) @(negedge clk);
    check(lk_req == '0 && pa_valid == '0, "R3 idle", {lk_req, pa_valid}, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule